// File: doc/BRIEF.md
# Location Monitor Interrupt Router

This block collects event pulses from four location monitors and steers them onto eight local interrupt lines. Each monitor raises a one-cycle hit pulse. The block records that pulse in a sticky status bit, and the bit holds until software clears it. A programmable 3-bit destination field for each source selects the line that the status bit drives. Several sources may share one line. Each line is the OR of every active source routed to it.

Software uses a plain 32-bit register port. A write takes effect at the clock edge. A read is combinational from the address. The port has two registers:

- A mapping register holds the destination fields.
- A status register reports the sticky bits. A bit in this register is cleared by writing a one to it.

The interrupt lines are registered and active high. There is no enable or priority stage; the block performs routing only.

Top module: `lm_irq_router`

## Requirements
- R1: After reset, all status bits, all destination fields, the read data at either register offset, and all eight lines are zero.
- R2: A one-cycle hit on source s sets status bit s. The bit is visible at status register bit 16+s after the clock edge that samples the hit. It stays set until it is cleared.
- R3: Writing the status register with a one at bit 16+s clears status bit s at that edge. Writing a zero at that bit leaves the status bit unchanged.
- R4: When a hit and a clear write for the same source arrive in the same cycle, that status bit stays set.
- R5: The mapping register holds the source fields at bits [18:16], [22:20], [26:24] and [30:28], for sources 0 to 3. Each field reads back as written. All other bits of the mapping register read zero.
- R6: Line n goes high one clock after the status bits and fields that select it. A field value v routes its source to line v, in binary. Line n is the OR of the status bits of every source whose field equals n.
- R7: The status register is at byte offset 0x304 and the mapping register at 0x340. Any other address reads zero, and writes to it change nothing. Status register bits outside 19:16 read zero.
- R8: Writing ones to the status register never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 4 | One-cycle hit pulse per location monitor |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i, combinational |
| irq_o | output | 8 | Local interrupt lines, registered, active high |

## Verification
The bench sweeps all sixteen hit patterns against sixteen computed field layouts. The layouts place several sources on the same line and reach every line value, so a router that kept only one source per line, or that swapped field bits, would raise the wrong lines.

It hits and clears the same source in the same cycle. A design that gave the clear priority would lose that event. It writes ones to status bits that are already clear; a status register written as ordinary storage would then set them. It writes zeros over set bits, which an implementation that overwrote the register rather than clearing selected bits would drop.

It writes through an unmapped address and then reads both registers. Incomplete address decoding would show there as a changed field or non-zero read data.

// File: rtl/lm_irq_pkg.sv
package lm_irq_pkg;
  parameter int unsigned NUM_SRC    = 4;
  parameter int unsigned NUM_LINES  = 8;
  parameter int unsigned MAP_W      = $clog2(NUM_LINES);
  parameter int unsigned DATA_W     = 32;
  parameter int unsigned ADDR_W     = 12;
  parameter int unsigned MAP_LSB    = 16;
  parameter int unsigned MAP_STRIDE = 4;
  parameter int unsigned STAT_LSB   = 16;
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h304;
  parameter logic [ADDR_W-1:0] MAP_OFS  = 12'h340;
endpackage

// File: rtl/lm_status_bank.sv
module lm_status_bank #(
  parameter int unsigned NumSrc = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NumSrc-1:0] hit_i,
  input  logic [NumSrc-1:0] clr_i,
  output logic [NumSrc-1:0] stat_o
);
  logic [NumSrc-1:0] stat_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit_i;
  end

  assign stat_o = stat_q;

  for (genvar s = 0; s < NumSrc; s++) begin : g_chk
    // R2
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[s] && !clr_i[s]) |=> stat_q[s]);
    // R3
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[s] && !hit_i[s]) |=> !stat_q[s]);
    // R4
    hit_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[s] |=> stat_q[s]);
    // R8
    no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_q[s] && !hit_i[s]) |=> !stat_q[s]);
  end
endmodule

// File: rtl/lm_map_reg.sv
module lm_map_reg #(
  parameter int unsigned NumSrc    = 4,
  parameter int unsigned MapW      = 3,
  parameter int unsigned DataW     = 32,
  parameter int unsigned MapLsb    = 16,
  parameter int unsigned MapStride = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [DataW-1:0]             wdata_i,
  output logic [NumSrc-1:0][MapW-1:0]  map_o,
  output logic [DataW-1:0]             word_o
);
  logic [NumSrc-1:0][MapW-1:0] map_q;

  for (genvar s = 0; s < NumSrc; s++) begin : g_fld
    localparam int unsigned Lsb = MapLsb + s * MapStride;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   map_q[s] <= '0;
      else if (wr_i) map_q[s] <= wdata_i[Lsb +: MapW];
    end
  end

  always_comb begin
    word_o = '0;
    for (int s = 0; s < NumSrc; s++) word_o[MapLsb + s*MapStride +: MapW] = map_q[s];
  end

  assign map_o = map_q;

  // R5
  map_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(map_q));
endmodule

// File: rtl/lm_line_router.sv
module lm_line_router #(
  parameter int unsigned NumSrc   = 4,
  parameter int unsigned NumLines = 8,
  parameter int unsigned MapW     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NumSrc-1:0]           stat_i,
  input  logic [NumSrc-1:0][MapW-1:0] map_i,
  output logic [NumLines-1:0]         irq_o
);
  logic [NumLines-1:0] line_d, line_q;

  always_comb begin
    line_d = '0;
    for (int s = 0; s < NumSrc; s++)
      if (stat_i[s]) line_d[map_i[s]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_d;
  end

  assign irq_o = line_q;

  // R6
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0) |=> (irq_o == '0));
  // R6
  line_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(irq_o) <= $countones($past(stat_i))));
endmodule

// File: rtl/lm_irq_router.sv
module lm_irq_router
  import lm_irq_pkg::*;
#(
  parameter int unsigned NumSrc   = lm_irq_pkg::NUM_SRC,
  parameter int unsigned NumLines = lm_irq_pkg::NUM_LINES,
  parameter int unsigned DataW    = lm_irq_pkg::DATA_W,
  parameter int unsigned AddrW    = lm_irq_pkg::ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NumSrc-1:0]   hit_i,
  input  logic                wr_en_i,
  input  logic [AddrW-1:0]    addr_i,
  input  logic [DataW-1:0]    wdata_i,
  output logic [DataW-1:0]    rdata_o,
  output logic [NumLines-1:0] irq_o
);
  localparam int unsigned MapW = $clog2(NumLines);

  logic sel_map, sel_stat;
  logic [NumSrc-1:0] stat, clr;
  logic [NumSrc-1:0][MapW-1:0] map;
  logic [DataW-1:0] map_word;

  // word-aligned decode
  assign sel_map  = addr_i[AddrW-1:2] == MAP_OFS[AddrW-1:2];
  assign sel_stat = addr_i[AddrW-1:2] == STAT_OFS[AddrW-1:2];
  assign clr      = (wr_en_i && sel_stat) ? wdata_i[STAT_LSB +: NumSrc] : '0;

  lm_status_bank #(.NumSrc(NumSrc)) i_status (
    .clk_i, .rst_ni, .hit_i, .clr_i(clr), .stat_o(stat)
  );

  lm_map_reg #(
    .NumSrc(NumSrc), .MapW(MapW), .DataW(DataW),
    .MapLsb(MAP_LSB), .MapStride(MAP_STRIDE)
  ) i_map (
    .clk_i, .rst_ni, .wr_i(wr_en_i && sel_map), .wdata_i,
    .map_o(map), .word_o(map_word)
  );

  lm_line_router #(.NumSrc(NumSrc), .NumLines(NumLines), .MapW(MapW)) i_route (
    .clk_i, .rst_ni, .stat_i(stat), .map_i(map), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (sel_map)       rdata_o = map_word;
    else if (sel_stat) rdata_o[STAT_LSB +: NumSrc] = stat;
  end

  // R7
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_map && !sel_stat) |-> (rdata_o == '0));
  // R7
  stat_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_stat |-> ((rdata_o & ~({{(DataW-NumSrc){1'b0}}, {NumSrc{1'b1}}} << STAT_LSB)) == '0));
endmodule

// File: tb/test_lm_irq_router.sv
module test_lm_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hit = '0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;
  int n_run = 0, n_fail = 0;

  localparam logic [11:0] A_STAT = 12'h304, A_MAP = 12'h340;

  always #10 clk = ~clk;

  lm_irq_router i_lm_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic [3:0] p);
    @(negedge clk); hit = p;
    @(negedge clk); hit = '0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic logic [2:0] fld(int cfg, int s);
    return 3'((cfg * 3 + s * 5 + (cfg >> 2) * s) & 7);
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] mapw;
    logic [7:0]  exp;
    #25 rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_MAP, d);  check("R1 map", d, 0);
    check("R1 irq", {24'h0, irq}, 0);

    // R5 field layout and masking
    wr(A_MAP, 32'hFFFF_FFFF);
    rd(A_MAP, d); check("R5 all ones", d, 32'h7777_0000);
    wr(A_MAP, 32'h0);

    for (int cfg = 0; cfg < 16; cfg++) begin
      mapw = 0;
      for (int s = 0; s < 4; s++) mapw[16 + 4*s +: 3] = fld(cfg, s);
      wr(A_MAP, mapw);
      rd(A_MAP, d); check("R5 readback", d, mapw);
      for (int p = 0; p < 16; p++) begin
        wr(A_STAT, 32'hFFFF_FFFF);
        pulse(4'(p));
        rd(A_STAT, d); check("R2 status", d, 32'(p) << 16);
        @(negedge clk);
        exp = '0;
        for (int s = 0; s < 4; s++) if (p[s]) exp[fld(cfg, s)] = 1'b1;
        check("R6 lines", {24'h0, irq}, {24'h0, exp});
      end
    end

    // R3 zero write keeps, one clears
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_MAP, 32'h3210_0000);
    pulse(4'hF);
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, d); check("R3 zero write", d, 32'h000F_0000);
    wr(A_STAT, 32'h0005_0000);
    rd(A_STAT, d); check("R3 clear", d, 32'h000A_0000);
    @(negedge clk);
    check("R6 after clear", {24'h0, irq}, 32'h0000_000A);
    // R2 sticky over idle cycles
    repeat (5) @(negedge clk);
    rd(A_STAT, d); check("R2 sticky", d, 32'h000A_0000);

    // R4 hit and clear together
    @(negedge clk); addr = A_STAT; wdata = 32'h0002_0000; wr_en = 1'b1; hit = 4'h2;
    @(negedge clk); wr_en = 1'b0; hit = '0;
    rd(A_STAT, d); check("R4 hit wins", d, 32'h000A_0000);

    // R8 writing ones to clear bits
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R8 no set", d, 0);
    @(negedge clk);
    check("R8 lines low", {24'h0, irq}, 0);

    // R7 unmapped address
    pulse(4'h4);
    wr(12'h300, 32'hFFFF_FFFF);
    wr(12'h344, 32'hFFFF_FFFF);
    rd(A_MAP, d);  check("R7 map untouched", d, 32'h3210_0000);
    rd(A_STAT, d); check("R7 status untouched", d, 32'h0004_0000);
    rd(12'h300, d); check("R7 unmapped read", d, 0);
    check("R6 line2", {24'h0, irq}, 32'h0000_0004);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_MAP, d);  check("R1 map after reset", d, 0);
    rd(A_STAT, d); check("R1 status after reset", d, 0);
    check("R1 irq after reset", {24'h0, irq}, 0);

    finish_run();
  end
endmodule